// File: doc/BRIEF.md
# Configuration Shadow Mismatch Monitor

This block keeps a bank of configuration words next to a shadow bank that must always hold their bitwise inverse. Every cycle outside a reload it checks all bit pairs. If any configuration bit equals its shadow bit, it raises a reset request, clears an active-low cause flag and reloads every word from a non-volatile image. A reload also follows power-on reset and any other hard reset.

The image is read through a plain word port. The block drives a read enable and an address, and the image returns the word on `rd_data` in the same cycle. Each reload cycle writes one word into the configuration bank and its inverse into the shadow bank. Two upset inputs flip stored bits in either bank for one cycle. They model a disturbance event, so that corruption can be produced at the ports. Software can write the cause flag back to 1.

Top module: `cfg_shadow_monitor`

## Requirements
- R1: Outside a reload, if any configuration bit equals its shadow bit at a clock edge, `mm_rst_req` is 1 after that edge. The bit equality comes from upsets applied at the previous edge.
- R2: Flipping the same bit position in both banks at the same edge keeps the pair complementary. No request is raised, and `cfg_words` shows the flipped value.
- R3: `mm_rst_req` stays 1 for exactly NWORDS cycles, which is the whole reload that the mismatch starts. It goes to 0 at the edge that writes the last word.
- R4: A reload starts at power-on release, on a `hard_rst` pulse and on a mismatch. It reads addresses 0 to NWORDS-1 in order, one per cycle, with `rd_en` high. Word w occupies `cfg_words[w*WIDTH +: WIDTH]`. `rd_en` falls after the last word, and `cfg_words` then equals the image.
- R5: `cause_n` is 1 after power-on reset and becomes 0 at the edge where a mismatch is detected. A `hard_rst` reload neither changes it nor raises `mm_rst_req`.
- R6: A 1 on `sw_set` at an edge sets `cause_n` to 1. A mismatch detected at the same edge wins, and `cause_n` is 0.
- R7: The comparison is ignored while a reload runs. An upset to a word not yet reloaded is overwritten without a request. An upset to a word already reloaded trips the request one edge after the reload ends.
- R8: While `por_n` is 0, the outputs are as follows: `cfg_words` is 0, `mm_rst_req` is 0, `cause_n` is 1, `rd_en` is 1 and `rd_addr` is 0.
- R9: Outside a reload, changing the image does not change `cfg_words`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hard_rst | input | 1 | Pulse from any other hard reset source; starts a reload |
| sw_set | input | 1 | Software write that sets `cause_n` to 1 |
| upset_cfg | input | NWORDS*WIDTH | One-cycle bit flips applied to the configuration bank |
| upset_shd | input | NWORDS*WIDTH | One-cycle bit flips applied to the shadow bank |
| rd_data | input | WIDTH | Image word at `rd_addr`, valid in the same cycle |
| rd_en | output | 1 | Reload in progress; image read active |
| rd_addr | output | AW | Image word being read |
| mm_rst_req | output | 1 | Mismatch reset request |
| cause_n | output | 1 | Sticky mismatch cause flag, active low |
| cfg_words | output | NWORDS*WIDTH | Configuration bank contents |

## Verification
A shadow word loaded with something other than the inverse of its configuration word shows up at the ports one edge after the reload ends. `mm_rst_req` rises with no upset applied, and `cause_n` drops. A reload that skips or misorders addresses leaves `cfg_words` different from the image at the end of the reload. A mask that ends too early raises the request while `rd_en` is still high. A flag that any reset clears or sets would show the wrong `cause_n` right after a `hard_rst` reload.

// File: rtl/cfg_shadow_monitor.sv
module cfg_shadow_monitor #(
  parameter int NWORDS = 4,
  parameter int WIDTH  = 16,
  localparam int AW    = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int TOT   = NWORDS * WIDTH
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           hard_rst,
  input  logic           sw_set,
  input  logic [TOT-1:0] upset_cfg,
  input  logic [TOT-1:0] upset_shd,
  input  logic [WIDTH-1:0] rd_data,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           mm_rst_req,
  output logic           cause_n,
  output logic [TOT-1:0] cfg_words
);

  logic [TOT-1:0] cfg_q, shd_q, cfg_n, shd_n;
  logic           loading;
  logic [AW-1:0]  idx;

  wire last     = idx == AW'(NWORDS - 1);
  wire mismatch = ~&(cfg_q ^ shd_q);
  wire trip     = !loading && mismatch;
  wire restart  = trip || hard_rst;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    wire we = loading && (idx == AW'(w));
    assign cfg_n[w*WIDTH +: WIDTH] = we ? rd_data
                                        : cfg_q[w*WIDTH +: WIDTH] ^ upset_cfg[w*WIDTH +: WIDTH];
    assign shd_n[w*WIDTH +: WIDTH] = we ? ~rd_data
                                        : shd_q[w*WIDTH +: WIDTH] ^ upset_shd[w*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q      <= '0;
      shd_q      <= '0;
      loading    <= 1'b1;
      idx        <= '0;
      mm_rst_req <= 1'b0;
      cause_n    <= 1'b1;
    end else begin
      cfg_q <= cfg_n;
      shd_q <= shd_n;
      if (restart) begin
        loading <= 1'b1;
        idx     <= '0;
      end else if (loading) begin
        if (last) begin
          loading    <= 1'b0;
          idx        <= '0;
          mm_rst_req <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (trip) mm_rst_req <= 1'b1;
      if (trip)        cause_n <= 1'b0;
      else if (sw_set) cause_n <= 1'b1;
    end
  end

  assign rd_en     = loading;
  assign rd_addr   = idx;
  assign cfg_words = cfg_q;

endmodule

// File: rtl/cfg_shadow_monitor_chk.sv
module cfg_shadow_monitor_chk #(
  parameter int TOT = 64
) (
  input logic           clk,
  input logic           por_n,
  input logic           sw_set,
  input logic           rd_en,
  input logic           mm_rst_req,
  input logic           cause_n,
  input logic [TOT-1:0] cfg_q,
  input logic [TOT-1:0] shd_q
);

  AST_TRIP_RAISES_REQ: assert property (@(posedge clk) disable iff (!por_n)
    (!rd_en && !(&(cfg_q ^ shd_q))) |=> mm_rst_req);  // R1

  AST_REQ_ONLY_IN_RELOAD: assert property (@(posedge clk) disable iff (!por_n)
    mm_rst_req |-> rd_en);  // R3

  AST_REQ_RISE_CLEARS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mm_rst_req) |-> !cause_n);  // R5

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (!cause_n && !sw_set) |=> !cause_n);  // R5

  AST_SW_SET_WORKS: assert property (@(posedge clk) disable iff (!por_n)
    (sw_set && (rd_en || (&(cfg_q ^ shd_q)))) |=> cause_n);  // R6

endmodule

bind cfg_shadow_monitor cfg_shadow_monitor_chk #(.TOT(NWORDS * WIDTH)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .sw_set     (sw_set),
  .rd_en      (rd_en),
  .mm_rst_req (mm_rst_req),
  .cause_n    (cause_n),
  .cfg_q      (cfg_q),
  .shd_q      (shd_q)
);

// File: tb/cfg_shadow_monitor_test.sv
module cfg_shadow_monitor_test;
  localparam int NW  = 4;
  localparam int W   = 16;
  localparam int TOT = NW * W;

  typedef struct packed {
    logic [TOT-1:0] ucfg;
    logic [TOT-1:0] ushd;
    logic [W-1:0]   seed;
    logic           trip;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{64'h0000_0000_0000_0001, 64'h0, 16'hA5A0, 1'b1},
    '{64'h0, 64'h8000_0000_0000_0000, 16'h3C10, 1'b1},
    '{64'h0000_0010_0000_0000, 64'h0000_0010_0000_0000, 16'h7700, 1'b0},
    '{64'h0000_0000_0000_0100, 64'h0000_0000_0002_0000, 16'h0F0F, 1'b1},
    '{64'h0, 64'h0, 16'hFFF0, 1'b0}
  };

  logic clk = 0, por_n = 0, hard_rst = 0, sw_set = 0;
  logic [TOT-1:0] upset_cfg = '0, upset_shd = '0;
  logic [W-1:0] img [NW];
  logic [W-1:0] rd_data;
  logic rd_en, mm_rst_req, cause_n;
  logic [1:0] rd_addr;
  logic [TOT-1:0] cfg_words, model;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign rd_data = img[rd_addr];

  cfg_shadow_monitor uut (
    .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .sw_set(sw_set),
    .upset_cfg(upset_cfg), .upset_shd(upset_shd), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .mm_rst_req(mm_rst_req),
    .cause_n(cause_n), .cfg_words(cfg_words)
  );

  function automatic logic [TOT-1:0] pack(logic [W-1:0] s);
    logic [TOT-1:0] r;
    for (int w = 0; w < NW; w++) r[w*W +: W] = s + W'(w);
    return r;
  endfunction

  task automatic set_img(logic [W-1:0] s);
    for (int w = 0; w < NW; w++) img[w] = s + W'(w);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, logic [TOT-1:0] act, logic [TOT-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    set_img(16'h1230);
    repeat (3) step();
    chk(cfg_words == '0, "R8 cfg", cfg_words, '0);
    chk(mm_rst_req == 0 && cause_n == 1, "R8 req/cause", {mm_rst_req, cause_n}, 2'b01);
    chk(rd_en == 1 && rd_addr == 0, "R8 rd", {rd_en, rd_addr}, 3'b100);
    por_n = 1;
    repeat (NW - 1) step();
    chk(rd_en == 1, "R4 still loading", rd_en, 1);
    step();
    chk(rd_en == 0 && cfg_words == pack(16'h1230), "R4 por reload", cfg_words, pack(16'h1230));
    chk(mm_rst_req == 0 && cause_n == 1, "R5 after por", {mm_rst_req, cause_n}, 2'b01);
    model = pack(16'h1230);

    foreach (VECS[i]) begin
      set_img(VECS[i].seed);
      step();
      chk(cfg_words == model, "R9 idle image change", cfg_words, model);
      upset_cfg = VECS[i].ucfg;
      upset_shd = VECS[i].ushd;
      step();
      upset_cfg = '0;
      upset_shd = '0;
      step();
      chk(mm_rst_req == VECS[i].trip, "R1/R2 request", mm_rst_req, VECS[i].trip);
      if (VECS[i].trip) begin
        chk(cause_n == 0, "R5 cause cleared", cause_n, 0);
        repeat (NW - 1) step();
        chk(mm_rst_req == 1, "R3 held", mm_rst_req, 1);
        step();
        chk(mm_rst_req == 0 && rd_en == 0, "R3 released", {mm_rst_req, rd_en}, 0);
        model = pack(VECS[i].seed);
        chk(cfg_words == model, "R4 reloaded", cfg_words, model);
      end else begin
        model = model ^ VECS[i].ucfg;
        chk(cfg_words == model && rd_en == 0, "R2 flipped pair kept", cfg_words, model);
      end
      sw_set = 1;
      step();
      sw_set = 0;
      chk(cause_n == 1, "R6 sw set", cause_n, 1);
    end

    // R5: hard reset after a mismatch leaves cause low, no request
    upset_shd = 64'h1;
    step();
    upset_shd = '0;
    repeat (NW + 1) step();
    chk(cause_n == 0 && rd_en == 0, "R5 tripped", {cause_n, rd_en}, 0);
    set_img(16'h4400);
    hard_rst = 1;
    step();
    hard_rst = 0;
    chk(mm_rst_req == 0 && rd_en == 1, "R5 hard no req", {mm_rst_req, rd_en}, 2'b01);
    repeat (NW) step();
    chk(cfg_words == pack(16'h4400), "R4 hard reload", cfg_words, pack(16'h4400));
    chk(cause_n == 0 && mm_rst_req == 0, "R5 cause kept", {cause_n, mm_rst_req}, 0);

    // R6: mismatch and software write at the same edge
    sw_set = 1;
    step();
    sw_set = 0;
    chk(cause_n == 1, "R6 set", cause_n, 1);
    upset_cfg = 64'h0000_0000_0040_0000;
    step();
    upset_cfg = '0;
    sw_set = 1;
    step();
    sw_set = 0;
    chk(cause_n == 0 && mm_rst_req == 1, "R6 mismatch wins", {cause_n, mm_rst_req}, 2'b01);
    repeat (NW) step();
    sw_set = 1;
    step();
    sw_set = 0;
    chk(cause_n == 1 && rd_en == 0, "R6 restored", {cause_n, rd_en}, 2'b10);

    // R7: comparison masked during reload
    set_img(16'h5500);
    hard_rst = 1;
    step();
    hard_rst = 0;
    step();
    upset_cfg = 64'h0001_0000_0000_0002;
    step();
    upset_cfg = '0;
    chk(mm_rst_req == 0, "R7 masked", mm_rst_req, 0);
    repeat (NW - 2) step();
    chk(mm_rst_req == 0 && rd_en == 0, "R7 masked to end", {mm_rst_req, rd_en}, 0);
    chk(cfg_words == (pack(16'h5500) ^ 64'h2), "R7 late word overwritten",
        cfg_words, pack(16'h5500) ^ 64'h2);
    step();
    chk(mm_rst_req == 1 && cause_n == 0, "R7 trips after reload", {mm_rst_req, cause_n}, 2'b10);
    repeat (NW) step();
    chk(cfg_words == pack(16'h5500), "R4 repaired", cfg_words, pack(16'h5500));

    finish_run();
  end
endmodule